// File: doc/BRIEF.md
# Network Controller Interrupt Status and Enable Unit

This block gathers the interrupt events of a network controller in one host-visible register pair. Single-cycle event pulses from the transmit and receive engines set sticky bits in a 32-bit status word. A matching 32-bit enable word selects which of those bits count toward two summary flags. The "normal" flag covers completion events. The "abnormal" flag covers stop, unavailable, timeout, underflow and bus-error events. A single interrupt line goes high while an enabled summary flag is set.

Host software reads the status word over a simple register port. It acknowledges events by writing ones to the bits it wants cleared. Writing back the exact value it just read therefore acknowledges every event that read showed. The same word also carries three read-only 3-bit fields: the receive process state, the transmit process state and an error code. These are driven live by the DMA engines outside the block. Reads are combinational on the address. A write takes effect at the clock edge on which select and write-enable are high.

Top module: `nic_irq_unit`

## Requirements
- R1: After reset every sticky status bit and every enable bit reads 0 and `irq` is low.
- R2: A pulse on `evt_pulse[i]` for a mapped event bit i sets status bit i at that clock edge, and the bit stays set until it is cleared. Bit map: 0 tx done, 1 tx stopped, 2 tx buffer unavailable, 3 tx jabber, 5 tx underflow, 6 rx done, 7 rx buffer unavailable, 8 rx stopped, 9 rx watchdog, 10 early tx, 11 timer expired, 13 fatal bus error.
- R3: A write to the status address (`bus_addr` = 0) clears every mapped bit where `bus_wdata` holds a one and leaves the bits written with zero unchanged.
- R4: When an event pulse and a write-one clear reach the same bit in the same cycle, the bit stays set.
- R5: A write to the enable address (`bus_addr` = 1) stores the bits at the mapped event positions plus bits 15 and 16. Every other enable bit reads 0.
- R6: Status bit 16 (normal summary) reads 1 exactly when at least one of status bits 0, 2 or 6 is set with its enable bit set.
- R7: Status bit 15 (abnormal summary) reads 1 exactly when at least one of status bits 1, 3, 5, 7, 8, 9 or 13 is set with its enable bit set.
- R8: `irq` is high exactly when (status bit 16 and enable bit 16) or (status bit 15 and enable bit 15).
- R9: Status bits 19:17 show `rx_state`, bits 22:20 show `tx_state` and bits 25:23 show `err_code`. Writes to those bits, and writes of one to bits 15 and 16, have no effect.
- R10: Writing back the status value just read leaves every sticky bit clear, unless a new event arrived in the same cycle.
- R11: Bits 10 and 11 are sticky but feed neither summary flag. Status bits 4, 12, 14 and 26–31 always read 0, and pulses on those positions are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pulse | input | 32 | One-cycle event pulses, at the status bit positions |
| rx_state | input | 3 | Receive process state code |
| tx_state | input | 3 | Transmit process state code |
| err_code | input | 3 | Error code |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, valid with `bus_sel` |
| bus_addr | input | ADDR_W | Word address: 0 status, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit address, status at word 0 and enable at word 1, and a two-stage reset synchroniser. With these values an unused address reads as zero, and the delay between reset release and the first accepted write is reachable. The vector walk drives events and clears in the same cycles, with both summary groups and the unmapped positions exercised while all enables are set. The directed tests then remove the enables one at a time to separate the summary gating from the interrupt gating.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 3;
  localparam int AIS_BIT = 15;
  localparam int NIS_BIT = 16;
  localparam int RXS_LSB = 17;
  localparam int TXS_LSB = RXS_LSB + FIELD_W;
  localparam int ERR_LSB = TXS_LSB + FIELD_W;
  localparam int N_GRP   = 2;

  // sticky event positions
  localparam logic [WORD_W-1:0] EVT_MASK  = 32'h0000_2FEF;
  // completion events feeding the normal summary
  localparam logic [WORD_W-1:0] NORM_MASK = 32'h0000_0045;
  // error / stall events feeding the abnormal summary
  localparam logic [WORD_W-1:0] ABN_MASK  = 32'h0000_23AA;
  // writable enable bits
  localparam logic [WORD_W-1:0] EN_MASK   = EVT_MASK | (32'h1 << AIS_BIT) | (32'h1 << NIS_BIT);
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         upd;

  // set has priority over clear
  always_comb begin
    q_d = ((q_r & ~clr) | evt) & MASK;
    upd = |((evt | clr) & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_d;
  end

  assign q = q_r;

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (MASK[i]) begin : g_mapped
      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> q[i]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q[i] && !clr[i]) |=> q[i]);
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !evt[i]) |=> !q[i]);
      p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && evt[i]) |=> q[i]);
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import nic_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] stat,
  input  logic [WORD_W-1:0] en,
  output logic              nis,
  output logic              ais,
  output logic              irq
);
  localparam logic [WORD_W-1:0] GRP_MASK [N_GRP] = '{NORM_MASK, ABN_MASK};
  localparam int                GRP_EN   [N_GRP] = '{NIS_BIT, AIS_BIT};

  logic [N_GRP-1:0] sum;
  logic [N_GRP-1:0] req;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign sum[g] = |(stat & en & GRP_MASK[g]);
    assign req[g] = sum[g] & en[GRP_EN[g]];
  end

  assign nis = sum[0];
  assign ais = sum[1];
  assign irq = |req;

  p_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en[NIS_BIT] || en[AIS_BIT]));
  p_nis_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nis |-> (|(stat & NORM_MASK)));
  p_ais_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ais |-> (|(stat & ABN_MASK)));
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int EN_ADDR   = 1,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       evt_pulse,
  input  logic [2:0]        rx_state,
  input  logic [2:0]        tx_state,
  input  logic [2:0]        err_code,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

  logic              rst_i_n;
  logic              wr_stat;
  logic              wr_en;
  logic [WORD_W-1:0] evt_m;
  logic [WORD_W-1:0] clr_m;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] en_q;
  logic [WORD_W-1:0] en_d;
  logic [WORD_W-1:0] stat_word;
  logic              nis;
  logic              ais;

  irq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    wr_stat = bus_sel && bus_we && (bus_addr == A_STAT);
    wr_en   = bus_sel && bus_we && (bus_addr == A_EN);
    evt_m   = evt_pulse & EVT_MASK;
    clr_m   = wr_stat ? (bus_wdata & EVT_MASK) : '0;
  end

  irq_sticky_bank #(.W(WORD_W), .MASK(EVT_MASK)) u_stat (
    .clk   (clk),
    .rst_n (rst_i_n),
    .evt   (evt_m),
    .clr   (clr_m),
    .q     (stat_q)
  );

  // enable register: next state, then register with clock enable
  always_comb begin
    en_d = bus_wdata & EN_MASK;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  irq_summary u_sum (
    .clk   (clk),
    .rst_n (rst_i_n),
    .stat  (stat_q),
    .en    (en_q),
    .nis   (nis),
    .ais   (ais),
    .irq   (irq)
  );

  always_comb begin
    stat_word = stat_q;
    stat_word[NIS_BIT] = nis;
    stat_word[AIS_BIT] = ais;
    stat_word[RXS_LSB +: FIELD_W] = rx_state;
    stat_word[TXS_LSB +: FIELD_W] = tx_state;
    stat_word[ERR_LSB +: FIELD_W] = err_code;
  end

  always_comb begin
    if (bus_addr == A_STAT)    bus_rdata = stat_word;
    else if (bus_addr == A_EN) bus_rdata = en_q;
    else                       bus_rdata = '0;
  end

  p_en_stable_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wr_en |=> $stable(en_q));
  p_en_load_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |=> (en_q == ($past(bus_wdata) & EN_MASK)));
  p_quiet_irq_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/sim_nic_irq_unit.sv
module sim_nic_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_pulse;
  logic [2:0]  rx_state, tx_state, err_code;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  nic_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .rx_state(rx_state), .tx_state(tx_state), .err_code(err_code),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {event pulses, clear data, expected status read, expected irq}
  localparam int NV = 9;
  localparam logic [96:0] VEC [NV] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0001_0001, 1'b1},
    {32'h0000_0400, 32'h0000_0001, 32'h0000_0400, 1'b0},
    {32'h0000_2000, 32'h0000_0000, 32'h0000_A400, 1'b1},
    {32'h0000_0044, 32'h0000_0400, 32'h0001_A044, 1'b1},
    {32'h0000_0040, 32'h0000_0040, 32'h0001_A044, 1'b1},
    {32'h0000_1000, 32'h0000_2000, 32'h0001_0044, 1'b1},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {32'h0000_0380, 32'h0000_0000, 32'h0000_8380, 1'b1},
    {32'h0000_4000, 32'h0000_0380, 32'h0000_0000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(posedge clk); #1;
    evt_pulse = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; evt_pulse = '0; rx_state = '0; tx_state = '0; err_code = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    bus_read(4'd0, rd); check("R1 status", rd, 32'h0);
    bus_read(4'd1, rd); check("R1 enable", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R5 enable readback mask
    bus_write(4'd1, 32'hFFFF_FFFF);
    bus_read(4'd1, rd); check("R5 enable mask", rd, 32'h0001_AFEF);
    bus_read(4'd2, rd); check("R5 unused address", rd, 32'h0);

    // vector walk: events and clears in the same cycle, all enables on
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      evt_pulse = VEC[v][96:65];
      if (VEC[v][64:33] != 32'h0) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = VEC[v][64:33];
      end
      @(posedge clk); #1;
      evt_pulse = '0; bus_sel = 1'b0; bus_we = 1'b0;
      bus_read(4'd0, rd);
      check("R2 R3 R4 R6 R7 R11 vector status", rd, VEC[v][32:1]);
      check("R8 vector irq", {31'b0, irq}, {31'b0, VEC[v][0]});
    end

    // R9 read-only fields
    rx_state = 3'd5; tx_state = 3'd3; err_code = 3'd6;
    bus_read(4'd0, rd); check("R9 fields", rd, 32'h033A_0000);
    bus_write(4'd0, 32'h03FF_8000);
    bus_read(4'd0, rd); check("R9 write ignored", rd, 32'h033A_0000);
    rx_state = '0; tx_state = '0; err_code = '0;

    // R8 summary enables gate irq
    bus_write(4'd1, 32'h0000_2FEF);
    pulse(32'h0000_0002);
    bus_read(4'd0, rd); check("R7 abnormal summary", rd, 32'h0000_8002);
    check("R8 irq without summary enable", {31'b0, irq}, 32'h0);
    bus_write(4'd1, 32'h0000_AFEF);
    #1 check("R8 irq with abnormal enable", {31'b0, irq}, 32'h1);
    bus_write(4'd1, 32'h0001_0000);
    bus_read(4'd0, rd); check("R7 source enable gates summary", rd, 32'h0000_0002);
    check("R8 irq off", {31'b0, irq}, 32'h0);

    // R6 normal summary needs the source enable
    pulse(32'h0000_0001);
    bus_read(4'd0, rd); check("R6 bit0 not enabled", rd, 32'h0000_0003);
    check("R8 irq off normal", {31'b0, irq}, 32'h0);
    bus_write(4'd1, 32'h0001_0001);
    bus_read(4'd0, rd); check("R6 normal summary", rd, 32'h0001_0003);
    check("R8 irq normal", {31'b0, irq}, 32'h1);

    // R11 bits 10/11 no summary; R10 write back of read value
    bus_write(4'd1, 32'h0001_AFEF);
    pulse(32'h0000_0C00);
    bus_read(4'd0, rd); check("R11 timer bits sticky", rd, 32'h0001_8C03);
    rx_state = 3'd2;
    bus_read(4'd0, rd);
    bus_write(4'd0, rd);
    bus_read(4'd0, rd); check("R10 write back clears", rd, 32'h0004_0000);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    pulse(32'h0000_0C00);
    bus_read(4'd0, rd); check("R11 timer bits no irq", {31'b0, irq}, 32'h0);
    rx_state = 3'd0;

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #2 check("R1 async clear irq", {31'b0, irq}, 32'h0);
    bus_read(4'd0, rd); check("R1 status after reset", rd, 32'h0);
    bus_read(4'd1, rd); check("R1 enable after reset", rd, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule